// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache

This block is a 4 KB direct-mapped read cache with one 32-bit word per line. A load offers only the word-select bits of its page offset. The translation buffer resolves the page number of the same load in the same cycle. Because every index bit lies inside the page offset, the line store can be read before translation finishes. The stored tag is then compared against the physical frame number that the translation buffer returns.

A lookup resolves in the cycle after the load is accepted, and it has one of three outcomes:

- When the translation missed, the block raises a translation request and returns nothing.
- When the translation hit and the line is valid with a matching frame tag, the word is returned.
- In every other case the block reads main memory at the physical word address built from the frame number and the index. When memory answers, it forwards that word and keeps it in the line together with the frame number as tag.

The index width is derived as the page-offset width minus the byte-offset width. The cache size can therefore never outgrow a page. A larger cache would need more ways, not more index bits.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid, ready is 1, and rsp_valid, xlate_req and mem_req are 0. The first translated access to any index then goes to memory.
- R2: The line is selected only by req_idx, which holds address bits [11:2]. Two accesses with the same index and different frame numbers compete for one line. Indices 0 and 1023 behave like any other.
- R3: An accepted access that has a translation hit, a valid line and an equal tag raises rsp_valid in the next cycle, with the stored word on rsp_data and mem_req at 0.
- R4: An accepted access that has a translation hit and either an invalid line or an unequal tag raises mem_req in the next cycle. At the same time mem_addr is {frame number, req_idx, 2'b00} and rsp_valid is 0.
- R5: An accepted access with tlb_hit at 0 raises xlate_req for one cycle in the next cycle, with rsp_valid and mem_req at 0. The addressed line is left unchanged.
- R6: mem_req stays high with a stable mem_addr until mem_ack. In the mem_ack cycle, rsp_valid is 1 and rsp_data equals mem_data. In the following cycle mem_req is 0.
- R7: After a fill, an access with the same index and frame number hits and returns the filled word.
- R8: ready is 0 while a memory read is outstanding. A request presented while ready is 0 is ignored and produces no result.
- R9: mem_addr is always word aligned (bits [1:0] are 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request |
| req_idx | input | 10 | Virtual address bits [11:2] (line index) |
| tlb_hit | input | 1 | Translation buffer hit for this request |
| tlb_pfn | input | 20 | Physical frame number from the translation buffer |
| ready | output | 1 | A request is accepted this cycle |
| rsp_valid | output | 1 | rsp_data holds the load result |
| rsp_data | output | 32 | Load data |
| xlate_req | output | 1 | Translation miss: full translation needed |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Physical word address of the read |
| mem_ack | input | 1 | Memory read data valid |
| mem_data | input | 32 | Memory read data |

## Verification
The bench aims at aliasing on one index with different frame numbers. A design that compared only the index, or that stored the virtual page, would return a stale word instead of going to memory. It sends translation misses onto lines that are already valid: a design that filled or cleared the line would lose the next hit. It uses memory latencies from zero upward, which exposes a controller that drops mem_req early or misses an acknowledge in the lookup cycle. It also offers requests while a fill is outstanding: a design that accepted them would show a spurious translation request after the fill.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic              rdv_q;
  logic [TAG_W-1:0]  rdt_q;
  logic [DATA_W-1:0] rdd_q;

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdt_q <= '0;
      rdd_q <= '0;
    end else if (rd_en) begin
      rdv_q <= valid_q[rd_idx];
      rdt_q <= tag_mem[rd_idx];
      rdd_q <= data_mem[rd_idx];
    end
  end

  assign rd_valid = rdv_q;
  assign rd_tag   = rdt_q;
  assign rd_data  = rdd_q;
endmodule

// File: rtl/vipt_tag_cmp.sv
module vipt_tag_cmp #(
  parameter int TAG_W = 20
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] xlat_pfn,
  output logic             line_hit
);
  always_comb line_hit = line_valid && (line_tag == xlat_pfn);
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20,
  parameter int OFF_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [IDX_W-1:0]        req_idx,
  input  logic                    tlb_hit,
  input  logic [TAG_W-1:0]        tlb_pfn,
  input  logic                    line_hit,
  input  logic                    mem_ack,
  output logic                    ready,
  output logic                    accept,
  output logic [TAG_W-1:0]        lk_pfn,
  output logic                    look_hit,
  output logic                    xlate_req,
  output logic                    mem_req,
  output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
  output logic                    fill_we,
  output logic [IDX_W-1:0]        fill_idx
);
  ctrl_state_e      state_q, state_d;
  logic [TAG_W-1:0] pfn_q, pfn_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             tlb_q, tlb_d;
  logic             look, go_fill;

  always_comb begin
    look     = (state_q == ST_LOOK);
    look_hit = look && tlb_q && line_hit;
    xlate_req = look && !tlb_q;
    go_fill  = look && tlb_q && !line_hit;
    mem_req  = go_fill || (state_q == ST_FILL);
    fill_we  = mem_req && mem_ack;
    ready    = (state_q == ST_IDLE) || (look && !go_fill);
    accept   = req_valid && ready;

    state_d = state_q;
    pfn_d   = pfn_q;
    idx_d   = idx_q;
    tlb_d   = tlb_q;
    if (fill_we)      state_d = ST_IDLE;
    else if (mem_req) state_d = ST_FILL;
    else if (accept)  state_d = ST_LOOK;
    else              state_d = ST_IDLE;
    if (accept) begin
      pfn_d = tlb_pfn;
      idx_d = req_idx;
      tlb_d = tlb_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pfn_q   <= '0;
      idx_q   <= '0;
      tlb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pfn_q   <= pfn_d;
      idx_q   <= idx_d;
      tlb_q   <= tlb_d;
    end
  end

  assign lk_pfn   = pfn_q;
  assign fill_idx = idx_q;
  assign mem_addr = {pfn_q, idx_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int PA_W       = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int OFF_W      = 2,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = PAGE_OFF_W - OFF_W,
  localparam int PFN_W     = PA_W - PAGE_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              tlb_hit,
  input  logic [PFN_W-1:0]  tlb_pfn,
  output logic              ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              xlate_req,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data
);
  logic              accept, look_hit, line_hit, fill_we;
  logic              rd_valid;
  logic [PFN_W-1:0]  rd_tag, lk_pfn;
  logic [DATA_W-1:0] rd_data;
  logic [IDX_W-1:0]  fill_idx;

  vipt_ctrl #(.IDX_W(IDX_W), .TAG_W(PFN_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .line_hit(line_hit),
    .mem_ack(mem_ack), .ready(ready), .accept(accept), .lk_pfn(lk_pfn),
    .look_hit(look_hit), .xlate_req(xlate_req), .mem_req(mem_req),
    .mem_addr(mem_addr), .fill_we(fill_we), .fill_idx(fill_idx)
  );

  vipt_line_store #(.IDX_W(IDX_W), .TAG_W(PFN_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_en(accept), .rd_idx(req_idx),
    .wr_en(fill_we), .wr_idx(fill_idx), .wr_tag(lk_pfn), .wr_data(mem_data),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  vipt_tag_cmp #(.TAG_W(PFN_W)) u_cmp (
    .line_valid(rd_valid), .line_tag(rd_tag), .xlat_pfn(lk_pfn),
    .line_hit(line_hit)
  );

  always_comb begin
    rsp_valid = look_hit || fill_we;
    rsp_data  = fill_we ? mem_data : rd_data;
  end
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            ready,
  input logic            rsp_valid,
  input logic            xlate_req,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_ack
);
  assert_xlate_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_req |-> (!rsp_valid && !mem_req));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ready);

  assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !mem_req) |-> $past(req_valid && ready));
endmodule

bind vipt_cache vipt_cache_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/sim_vipt_cache.sv
`timescale 1ns/1ps
module sim_vipt_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, tlb_hit, mem_ack;
  logic [9:0]  req_idx;
  logic [19:0] tlb_pfn;
  logic [31:0] mem_data;
  logic        ready, rsp_valid, xlate_req, mem_req;
  logic [31:0] rsp_data, mem_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit          ref_v   [1024];
  logic [19:0] ref_tag [1024];

  always #2.5 clk = ~clk;

  vipt_cache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .ready(ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .xlate_req(xlate_req),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_data(mem_data)
  );

  function automatic logic [31:0] memw(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // One load; lat = cycles of memory delay after the lookup cycle.
  // poke = offer an ignored request during the fill (needs lat >= 2).
  task automatic access(logic [9:0] idx, bit hit, logic [19:0] pfn, int lat, bit poke);
    logic [31:0] pa;
    pa = {pfn, idx, 2'b00};
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_idx = idx; tlb_hit = hit; tlb_pfn = pfn;
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) begin
      chk(xlate_req == 1'b1, "R5 xlate", {31'd0, xlate_req}, 32'd1);
      chk(rsp_valid == 1'b0, "R5 no rsp", {31'd0, rsp_valid}, 32'd0);
      chk(mem_req == 1'b0, "R5 no mem", {31'd0, mem_req}, 32'd0);
    end else if (ref_v[idx] && ref_tag[idx] == pfn) begin
      chk(rsp_valid == 1'b1 && mem_req == 1'b0, "R3/R7 hit", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_data == memw(pa), "R3/R7 data", rsp_data, memw(pa));
    end else begin
      chk(rsp_valid == 1'b0, "R4 no rsp", {31'd0, rsp_valid}, 32'd0);
      chk(mem_req == 1'b1 && mem_addr == pa, "R4/R2 addr", mem_addr, pa);
      chk(ready == 1'b0 && mem_addr[1:0] == 2'b00, "R8/R9", {31'd0, ready}, 32'd0);
      for (int i = 0; i < lat; i++) begin
        if (poke && i == 0) begin
          req_valid = 1'b1; req_idx = idx ^ 10'h155; tlb_hit = 1'b0;
        end else begin
          req_valid = 1'b0;
        end
        @(negedge clk);
        chk(mem_req == 1'b1 && mem_addr == pa, "R6 held", mem_addr, pa);
      end
      req_valid = 1'b0;
      mem_ack = 1'b1; mem_data = memw(pa);
      #1;
      chk(rsp_valid == 1'b1 && rsp_data == memw(pa), "R6 fwd", rsp_data, memw(pa));
      @(negedge clk);
      mem_ack = 1'b0;
      chk(mem_req == 1'b0, "R6 drop", {31'd0, mem_req}, 32'd0);
      if (poke) chk(xlate_req == 1'b0 && rsp_valid == 1'b0, "R8 ignored",
                    {31'd0, xlate_req}, 32'd0);
      ref_v[idx] = 1'b1;
      ref_tag[idx] = pfn;
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4713));
    for (int i = 0; i < 1024; i++) ref_v[i] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_idx = '0; tlb_hit = 1'b0;
    tlb_pfn = '0; mem_ack = 1'b0; mem_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", {31'd0, ready}, 32'd1);
    chk(!rsp_valid && !xlate_req && !mem_req, "R1 quiet",
        {29'd0, rsp_valid, xlate_req, mem_req}, 32'd0);

    // directed corners
    access(10'd0,    1'b1, 20'h12345, 0, 1'b0); // R1 cold miss, ack in lookup cycle
    access(10'd0,    1'b1, 20'h12345, 0, 1'b0); // R7 hit
    access(10'd1023, 1'b1, 20'hABCDE, 3, 1'b1); // R2 top index, R8 poke
    access(10'd1023, 1'b1, 20'hABCDE, 0, 1'b0); // R7 hit
    access(10'd0,    1'b1, 20'h54321, 1, 1'b0); // R4 tag mismatch
    access(10'd0,    1'b1, 20'h12345, 2, 1'b0); // R2 alias evicted
    access(10'd1023, 1'b0, 20'h00000, 0, 1'b0); // R5 on valid line
    access(10'd1023, 1'b1, 20'hABCDE, 0, 1'b0); // R5 line untouched

    // random traffic over a small pool so hits and conflicts occur
    for (int n = 0; n < 400; n++) begin
      logic [9:0]  ix;
      logic [19:0] pf;
      ix = ($urandom % 4 == 0) ? 10'($urandom) : 10'($urandom % 16);
      pf = 20'h40000 + 20'($urandom % 3);
      access(ix, ($urandom % 6) != 0, pf, int'($urandom % 4), ($urandom % 8) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule